// File: doc/BRIEF.md
# NAND Command and Address Front End

This block is the device-side front end of a small-page NAND memory. It watches an 8-bit multiplexed write bus made of a chip enable, a write strobe, a command-latch flag and an address-latch flag. Every byte taken on a rising write strobe is sorted into one of three kinds: command, address or data. Address bytes are gathered into a column register and a two-byte row register. Command bytes drive a small grammar checker. It accepts one-byte operations (read, status, reset) and two-step operations that need a setup opcode, a fixed number of address bytes and then a confirm opcode (program, erase).

When a sequence completes, the block raises a one-cycle start pulse for the memory array, together with the latched column and row. Program data bytes fill an internal page register from the addressed column upward, and the array reads that register through its own port. A busy flag is held from each array operation until the array reports completion. A status byte reports ready in bit 6 and fail in bit 0. The cell array itself, analog timing and any one-time-programmable area lie outside this block.

The bus inputs are sampled by the block clock and are expected to be synchronous to it. A write-strobe pulse must span at least one clock edge low and one clock edge high.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken only on a clock edge where the write strobe is seen high after being low on the previous edge, with chip enable low. Cycles with chip enable high have no effect.
- R2: Command-latch high with address-latch low is a command cycle. Address-latch high with command-latch low is an address cycle. Both low is a data cycle. A cycle with both flags high is ignored.
- R3: Opcode 00h followed by three address bytes (column, row low, row high) gives one read start pulse. The pulse comes two clock edges after the third strobe rises, with op_col equal to the column and op_row equal to {row high, row low}.
- R4: Opcode 80h, three address bytes, any number of data bytes and then 10h gives one program start pulse carrying the column and row. The data bytes are stored in the page register at consecutive columns starting at the addressed column.
- R5: Opcode 60h, two address bytes (row low, row high) and then D0h gives one erase start pulse. Its op_row has the five page-select bits [4:0] forced to zero (32 pages per block).
- R6: A confirm opcode (10h or D0h) that arrives without its matching setup, or after the wrong number of address bytes, produces no start pulse and sets status bit 0. Status bit 0 is cleared by the next accepted read, program or erase, or by a reset.
- R7: Opcode 70h gives a status pulse and leaves the pending sequence untouched. The status output is 40h when ready with no fail, 41h when ready after a fail, and 00h while busy; all other bits are 0.
- R8: Opcode FFh gives a reset pulse at any time. It clears busy, the fail bit and any partial sequence.
- R9: Busy rises together with each read, program or erase pulse and falls one edge after array_done is high. While busy, every opcode except 70h and FFh, and every address byte, is ignored.
- R10: Page-register writes stop after column 527. The spare columns 512 to 527 are reachable by continuing data bytes, and data bytes beyond the last column never wrap onto lower columns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, bytes taken on its rising edge |
| cle | input | 1 | Command-latch flag |
| ale | input | 1 | Address-latch flag |
| io_in | input | 8 | Multiplexed command/address/data byte |
| array_done | input | 1 | Array reports the current operation finished |
| arr_col | input | 10 | Page-register column read by the array |
| arr_data | output | 8 | Page-register byte at arr_col |
| rd_start | output | 1 | One-cycle read start |
| prog_start | output | 1 | One-cycle program start |
| erase_start | output | 1 | One-cycle erase start |
| stat_start | output | 1 | One-cycle status-read pulse |
| reset_start | output | 1 | One-cycle reset pulse |
| op_col | output | 8 | Column for the latest read or program |
| op_row | output | 16 | Row (page) for the latest operation, block-aligned for erase |
| busy | output | 1 | Array operation in progress |
| status | output | 8 | Status byte: bit 6 ready, bit 0 fail |

## Verification
A corrupted sequence state or address counter shows up as a missing, extra or misaddressed start pulse. It is seen two clock edges after the write strobe that should have completed the sequence, or it appears as a fail bit in the status byte on that same edge. A wrong data pointer shows up only when the array reads the page register back, so the bench reads columns at both ends of the page and in the spare area. A busy flag stuck in the wrong state is visible at once on the status byte, and it makes later commands disappear.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam int ROW_W = 16;

  localparam logic [7:0] OP_READ        = 8'h00;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG_EXEC   = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_EXEC  = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  typedef enum logic [1:0] {
    CYC_NONE,
    CYC_CMD,
    CYC_ADDR,
    CYC_DATA
  } cyc_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_READ,
    S_PROG,
    S_ERASE
  } seq_state_e;

  // Sort a write cycle by its latch flags; both flags high is not a legal cycle.
  function automatic cyc_kind_e cyc_kind(input logic cmd_flag, input logic addr_flag);
    case ({cmd_flag, addr_flag})
      2'b10:   return CYC_CMD;
      2'b01:   return CYC_ADDR;
      2'b00:   return CYC_DATA;
      default: return CYC_NONE;
    endcase
  endfunction

  // Clear the page-select bits of a row so that it names the first page of its block.
  function automatic logic [ROW_W-1:0] block_base(input logic [ROW_W-1:0] row, input int pg_bits);
    logic [ROW_W-1:0] keep;
    keep = {ROW_W{1'b1}} << pg_bits;
    return row & keep;
  endfunction

  // Status byte: bit 6 ready, bit 0 fail.
  function automatic logic [7:0] status_byte(input logic busy_f, input logic fail_f);
    return {1'b0, ~busy_f, 5'b0_0000, fail_f};
  endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
  import nand_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       cle,
  input  logic       ale,
  input  logic [7:0] io_in,
  output logic       cmd_stb,
  output logic       addr_stb,
  output logic       data_stb,
  output logic [7:0] bus_byte
);

  logic      we_prev;
  logic      take;
  cyc_kind_e kind;

  assign take = we_n & ~we_prev & ~ce_n;
  assign kind = cyc_kind(cle, ale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev  <= 1'b1;
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      data_stb <= 1'b0;
      bus_byte <= 8'h00;
    end else begin
      we_prev  <= we_n;
      cmd_stb  <= take && (kind == CYC_CMD);
      addr_stb <= take && (kind == CYC_ADDR);
      data_stb <= take && (kind == CYC_DATA);
      if (take) bus_byte <= io_in;
    end
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES      = 528,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int PTR_W           = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic             addr_stb,
  input  logic             data_stb,
  input  logic [7:0]       bus_byte,
  input  logic             array_done,
  output logic             rd_start,
  output logic             prog_start,
  output logic             erase_start,
  output logic             stat_start,
  output logic             reset_start,
  output logic [7:0]       op_col,
  output logic [ROW_W-1:0] op_row,
  output logic             busy,
  output logic             fail,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_col,
  output logic [7:0]       wr_byte
);

  localparam int PG_BITS = $clog2(PAGES_PER_BLOCK);
  localparam logic [2:0] CNT_MAX = 3'd4;

  seq_state_e       state;
  logic [2:0]       cnt;
  logic [7:0]       col_q;
  logic [7:0]       rlo_q;
  logic [7:0]       rhi_q;
  logic [PTR_W-1:0] ptr;

  assign wr_en   = data_stb && (state == S_PROG) && (cnt == 3'd3) && (ptr < PTR_W'(PAGE_BYTES));
  assign wr_col  = ptr;
  assign wr_byte = bus_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      col_q       <= '0;
      rlo_q       <= '0;
      rhi_q       <= '0;
      ptr         <= '0;
      busy        <= 1'b0;
      fail        <= 1'b0;
      op_col      <= '0;
      op_row      <= '0;
      rd_start    <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      stat_start  <= 1'b0;
      reset_start <= 1'b0;
    end else begin
      rd_start    <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      stat_start  <= 1'b0;
      reset_start <= 1'b0;
      if (array_done) busy <= 1'b0;

      if (cmd_stb) begin
        if (bus_byte == OP_RESET) begin
          state       <= S_IDLE;
          cnt         <= '0;
          busy        <= 1'b0;
          fail        <= 1'b0;
          reset_start <= 1'b1;
        end else if (bus_byte == OP_STATUS) begin
          stat_start <= 1'b1;
        end else if (!busy) begin
          case (bus_byte)
            OP_READ: begin
              state <= S_READ;
              cnt   <= '0;
            end
            OP_PROG_SETUP: begin
              state <= S_PROG;
              cnt   <= '0;
              ptr   <= '0;
            end
            OP_ERASE_SETUP: begin
              state <= S_ERASE;
              cnt   <= '0;
            end
            OP_PROG_EXEC: begin
              if (state == S_PROG && cnt == 3'd3) begin
                prog_start <= 1'b1;
                busy       <= 1'b1;
                fail       <= 1'b0;
                op_col     <= col_q;
                op_row     <= {rhi_q, rlo_q};
              end else begin
                fail <= 1'b1;
              end
              state <= S_IDLE;
            end
            OP_ERASE_EXEC: begin
              if (state == S_ERASE && cnt == 3'd2) begin
                erase_start <= 1'b1;
                busy        <= 1'b1;
                fail        <= 1'b0;
                op_col      <= '0;
                op_row      <= block_base({rhi_q, rlo_q}, PG_BITS);
              end else begin
                fail <= 1'b1;
              end
              state <= S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end else if (addr_stb) begin
        if (!busy && state != S_IDLE) begin
          if (cnt != CNT_MAX) cnt <= cnt + 3'd1;
          if (state == S_ERASE) begin
            if (cnt == 3'd0) rlo_q <= bus_byte;
            if (cnt == 3'd1) rhi_q <= bus_byte;
          end else begin
            if (cnt == 3'd0) begin
              col_q <= bus_byte;
              ptr   <= PTR_W'(bus_byte);
            end
            if (cnt == 3'd1) rlo_q <= bus_byte;
            if (cnt == 3'd2) rhi_q <= bus_byte;
            if (state == S_READ && cnt == 3'd2) begin
              rd_start <= 1'b1;
              busy     <= 1'b1;
              fail     <= 1'b0;
              op_col   <= col_q;
              op_row   <= {bus_byte, rlo_q};
              state    <= S_IDLE;
            end
          end
        end
      end else if (wr_en) begin
        ptr <= ptr + PTR_W'(1);
      end
    end
  end

endmodule

// File: rtl/nand_page_reg.sv
module nand_page_reg #(
  parameter int PAGE_BYTES = 528,
  parameter int PTR_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_col,
  input  logic [7:0]       wr_byte,
  input  logic [PTR_W-1:0] rd_col,
  output logic [7:0]       rd_byte
);

  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en && wr_col < PTR_W'(PAGE_BYTES)) mem[wr_col] <= wr_byte;
  end

  always_comb begin
    if (rd_col < PTR_W'(PAGE_BYTES)) rd_byte = mem[rd_col];
    else                             rd_byte = 8'h00;
  end

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES      = 528,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int PTR_W           = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             cle,
  input  logic             ale,
  input  logic [7:0]       io_in,
  input  logic             array_done,
  input  logic [PTR_W-1:0] arr_col,
  output logic [7:0]       arr_data,
  output logic             rd_start,
  output logic             prog_start,
  output logic             erase_start,
  output logic             stat_start,
  output logic             reset_start,
  output logic [7:0]       op_col,
  output logic [ROW_W-1:0] op_row,
  output logic             busy,
  output logic [7:0]       status
);

  logic             cmd_stb;
  logic             addr_stb;
  logic             data_stb;
  logic [7:0]       bus_byte;
  logic             fail;
  logic             wr_en;
  logic [PTR_W-1:0] wr_col;
  logic [7:0]       wr_byte;

  nand_bus_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .cle      (cle),
    .ale      (ale),
    .io_in    (io_in),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb),
    .data_stb (data_stb),
    .bus_byte (bus_byte)
  );

  nand_cmd_seq #(
    .PAGE_BYTES      (PAGE_BYTES),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PTR_W           (PTR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_stb     (cmd_stb),
    .addr_stb    (addr_stb),
    .data_stb    (data_stb),
    .bus_byte    (bus_byte),
    .array_done  (array_done),
    .rd_start    (rd_start),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .stat_start  (stat_start),
    .reset_start (reset_start),
    .op_col      (op_col),
    .op_row      (op_row),
    .busy        (busy),
    .fail        (fail),
    .wr_en       (wr_en),
    .wr_col      (wr_col),
    .wr_byte     (wr_byte)
  );

  nand_page_reg #(
    .PAGE_BYTES (PAGE_BYTES),
    .PTR_W      (PTR_W)
  ) u_page (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_col  (wr_col),
    .wr_byte (wr_byte),
    .rd_col  (arr_col),
    .rd_byte (arr_data)
  );

  assign status = status_byte(busy, fail);

endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk #(
  parameter int PAGES_PER_BLOCK = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_stb,
  input logic        addr_stb,
  input logic        rd_start,
  input logic        prog_start,
  input logic        erase_start,
  input logic        stat_start,
  input logic        reset_start,
  input logic        busy,
  input logic [7:0]  status,
  input logic [15:0] op_row
);

  localparam int PG_BITS = $clog2(PAGES_PER_BLOCK);

  logic any_op;
  assign any_op = rd_start | prog_start | erase_start;

  // R3 R4 R5 R7 R8
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, prog_start, erase_start, stat_start, reset_start}));

  // R1
  start_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_op | stat_start | reset_start) |-> $past(cmd_stb | addr_stb));

  // R9
  op_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_op |-> busy);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> any_op);

  // R5
  erase_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (op_row[PG_BITS-1:0] == '0));

  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_start |-> (!busy && !status[0]));

  // R6
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(cmd_stb));

endmodule

bind nand_cmd_front nand_cmd_front_chk #(.PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_stb     (cmd_stb),
  .addr_stb    (addr_stb),
  .rd_start    (rd_start),
  .prog_start  (prog_start),
  .erase_start (erase_start),
  .stat_start  (stat_start),
  .reset_start (reset_start),
  .busy        (busy),
  .status      (status),
  .op_row      (op_row)
);

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_PROG = 1, K_ERASE = 2, K_STAT = 3, K_RST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        cle = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  io_in = 8'h00;
  logic        array_done = 1'b0;
  logic [9:0]  arr_col = '0;
  logic [7:0]  arr_data;
  logic        rd_start, prog_start, erase_start, stat_start, reset_start;
  logic [7:0]  op_col;
  logic [15:0] op_row;
  logic        busy;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;
    logic [7:0]  col;
    logic [15:0] row;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .io_in(io_in), .array_done(array_done), .arr_col(arr_col), .arr_data(arr_data),
    .rd_start(rd_start), .prog_start(prog_start), .erase_start(erase_start),
    .stat_start(stat_start), .reset_start(reset_start), .op_col(op_col),
    .op_row(op_row), .busy(busy), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_op(input int kind, input logic [7:0] col, input logic [15:0] row, input string req);
    exp_t e;
    e.kind = kind; e.col = col; e.row = row; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: every start pulse is popped against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && (rd_start | prog_start | erase_start | stat_start | reset_start)) begin
      int k;
      exp_t e;
      k = rd_start ? K_RD : prog_start ? K_PROG : erase_start ? K_ERASE : stat_start ? K_STAT : K_RST;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1/R9: unexpected pulse kind %0d, expected none", k);
      end else begin
        e = exp_q.pop_front();
        if (k != e.kind) begin
          errors++;
          $display("FAIL %s: pulse kind %0d expected %0d", e.req, k, e.kind);
        end else if (k <= K_ERASE && (op_row !== e.row || (k != K_ERASE && op_col !== e.col))) begin
          errors++;
          $display("FAIL %s: col/row %0h/%0h expected %0h/%0h", e.req, op_col, op_row, e.col, e.row);
        end
      end
    end
  end

  task automatic bus_cycle(input logic c, input logic a, input logic [7:0] b, input logic ce);
    @(negedge clk);
    ce_n = ce; cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
  endtask

  task automatic cmd(input logic [7:0] b);  bus_cycle(1'b1, 1'b0, b, 1'b0); endtask
  task automatic addr(input logic [7:0] b); bus_cycle(1'b0, 1'b1, b, 1'b0); endtask
  task automatic dat(input logic [7:0] b);  bus_cycle(1'b0, 1'b0, b, 1'b0); endtask

  task automatic finish_array();
    @(negedge clk); array_done = 1'b1;
    @(negedge clk); array_done = 1'b0;
  endtask

  task automatic read_page(input logic [9:0] c, input logic [7:0] exp, input string req);
    @(negedge clk); arr_col = c;
    @(negedge clk); check(req, {24'h0, arr_data}, {24'h0, exp});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset status", {24'h0, status}, 32'h40);
    check("R9 reset busy", {31'h0, busy}, 32'h0);

    // R3 read with three address bytes
    expect_op(K_RD, 8'h12, 16'h5634, "R3");
    cmd(8'h00); addr(8'h12); addr(8'h34); addr(8'h56);
    check("R9 busy after read", {31'h0, busy}, 32'h1);
    check("R7 status while busy", {24'h0, status}, 32'h00);

    // R9 commands ignored while busy (monitor flags any pulse)
    cmd(8'h00); addr(8'h01); addr(8'h02); addr(8'h03);
    cmd(8'h60); addr(8'h01); addr(8'h02); cmd(8'hD0);
    check("R9 busy held", {24'h0, status}, 32'h00);
    finish_array();
    @(negedge clk);
    check("R9 busy cleared by done", {24'h0, status}, 32'h40);

    // R1 cycles with chip enable high have no effect: confirm then lacks its setup
    bus_cycle(1'b1, 1'b0, 8'h80, 1'b1);
    bus_cycle(1'b0, 1'b1, 8'h00, 1'b1);
    bus_cycle(1'b0, 1'b1, 8'h00, 1'b1);
    bus_cycle(1'b0, 1'b1, 8'h00, 1'b1);
    cmd(8'h10);
    check("R1 ce high ignored, R6 fail", {24'h0, status}, 32'h41);

    // R8 reset clears fail
    expect_op(K_RST, 8'h00, 16'h0000, "R8");
    cmd(8'hFF);
    check("R8 status after reset", {24'h0, status}, 32'h40);

    // R4 program with data
    expect_op(K_PROG, 8'hFC, 16'h0201, "R4");
    cmd(8'h80); addr(8'hFC); addr(8'h01); addr(8'h02);
    dat(8'hAA); dat(8'hBB); dat(8'hCC); dat(8'hDD);
    cmd(8'h10);
    check("R4 busy after program", {31'h0, busy}, 32'h1);
    finish_array();
    read_page(10'd252, 8'hAA, "R4 col 252");
    read_page(10'd255, 8'hDD, "R4 col 255");

    // R10 program column 0, then overrun the page end
    expect_op(K_PROG, 8'h00, 16'h0000, "R4");
    cmd(8'h80); addr(8'h00); addr(8'h00); addr(8'h00); dat(8'h5A); cmd(8'h10);
    finish_array();
    expect_op(K_PROG, 8'hF0, 16'h0000, "R10");
    cmd(8'h80); addr(8'hF0); addr(8'h00); addr(8'h00);
    for (int i = 0; i < 290; i++) dat(8'(i));
    cmd(8'h10);
    finish_array();
    read_page(10'd240, 8'h00, "R10 first column");
    read_page(10'd512, 8'h10, "R10 spare start");
    read_page(10'd527, 8'h1F, "R10 last column");
    read_page(10'd0, 8'h5A, "R10 no wrap");

    // R5 erase masks page bits
    expect_op(K_ERASE, 8'h00, 16'h1260, "R5");
    cmd(8'h60); addr(8'h7F); addr(8'h12); cmd(8'hD0);
    check("R5 busy after erase", {24'h0, status}, 32'h00);
    finish_array();
    @(negedge clk);
    check("R5 ready after erase", {24'h0, status}, 32'h40);

    // R6 wrong address counts and a bare confirm
    cmd(8'h60); addr(8'h01); cmd(8'hD0);
    check("R6 erase short address", {24'h0, status}, 32'h41);
    expect_op(K_RST, 8'h00, 16'h0000, "R8");
    cmd(8'hFF);
    cmd(8'h80); addr(8'h01); addr(8'h02); cmd(8'h10);
    check("R6 program short address", {24'h0, status}, 32'h41);
    cmd(8'hD0);
    check("R6 bare confirm", {24'h0, status}, 32'h41);

    // R7 status read keeps the fail bit
    expect_op(K_STAT, 8'h00, 16'h0000, "R7");
    cmd(8'h70);
    check("R7 status after status read", {24'h0, status}, 32'h41);

    // R6 accepted read clears fail
    expect_op(K_RD, 8'hA0, 16'hC0B0, "R6");
    cmd(8'h00); addr(8'hA0); addr(8'hB0); addr(8'hC0);
    check("R6 fail cleared by read", {24'h0, status}, 32'h00);
    finish_array();

    // R2 both latch flags high is ignored
    expect_op(K_RD, 8'h11, 16'h3322, "R2");
    cmd(8'h00); addr(8'h11);
    bus_cycle(1'b1, 1'b1, 8'h10, 1'b0);
    addr(8'h22); addr(8'h33);
    check("R2 no fail from illegal cycle", {24'h0, status}, 32'h00);
    finish_array();

    repeat (5) @(negedge clk);
    check("R3 all expected pulses seen", exp_q.size(), 32'h0);
    summary();
  end

endmodule